// File: doc/BRIEF.md
# Packed 15-bit Colour Palette

This block is a 256-entry colour lookup table for a display pipeline that runs at eight bits per pixel. Entries are packed two to a 32-bit word, so the table is 128 words deep. Word `w` holds entries `2w` and `2w+1`. Each entry is a 15-bit colour with three 5-bit components. The top bit of each 16-bit half always reads as zero.

Software-side writes name one entry by its 8-bit index and give red, green and blue as 16-bit magnitudes. The block keeps the five most significant bits of each component. It merges the new entry into its half of the shared word and leaves the neighbouring entry as it was. Writes only take effect while the eight-bit-per-pixel mode input is high. A registered word read port returns whole packed words, so the merging can be observed.

On the pixel side, an 8-bit index returns the colour one clock later. Each component is widened to 8 bits by repeating its top bits. A byte-order input inverts the least significant bit of the index before the half-word is chosen. It acts the same way for writes and for lookups.

Top module: `pal_lut`

## Requirements
- R1: With `swap_halves` low, entry n is stored in word n>>1. An even n occupies bits 15:0 of that word and an odd n occupies bits 31:16.
- R2: With `swap_halves` high, bit 0 of the index is inverted before the half is chosen, for both writes and lookups. Index n therefore uses the half that index n^1 uses in normal order.
- R3: An entry is packed as red in bits 4:0, green in bits 9:5 and blue in bits 14:10. Each 5-bit field is bits 15:11 of the 16-bit input component; bits 10:0 are discarded.
- R4: A write changes only the selected half-word. The other half of the same word and every other word keep their contents.
- R5: Bit 15 and bit 31 of every word read back as zero.
- R6: While `bpp8_en` is low, `wr_en` has no effect on the stored table.
- R7: `pix_red`, `pix_green` and `pix_blue` show the entry selected by `pix_index` and `swap_halves` one clock after they are presented. Each 5-bit field c is expanded to the 8-bit value {c, c[4:2]}.
- R8: `rd_word_data` shows the word selected by `rd_word_sel` one clock after it is presented.
- R9: Reset clears every entry to zero and drives `rd_word_data` and the pixel outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bpp8_en | input | 1 | High when the display runs at eight bits per pixel; gates writes |
| swap_halves | input | 1 | Byte-order control; inverts index bit 0 before half selection |
| wr_en | input | 1 | Write strobe for one entry |
| wr_index | input | 8 | Entry index to write |
| wr_red | input | 16 | Red magnitude; top 5 bits kept |
| wr_green | input | 16 | Green magnitude; top 5 bits kept |
| wr_blue | input | 16 | Blue magnitude; top 5 bits kept |
| rd_word_sel | input | 7 | Packed word to read back |
| rd_word_data | output | 32 | Registered packed word |
| pix_index | input | 8 | Pixel colour index |
| pix_red | output | 8 | Expanded red, registered |
| pix_green | output | 8 | Expanded green, registered |
| pix_blue | output | 8 | Expanded blue, registered |

## Verification
The bench builds the block with its default parameters: an 8-bit index, 16-bit input components, 5-bit fields and 8-bit outputs. At this size every one of the 256 entries and all 128 packed words can be written, read back and looked up, in both byte orders. Expected words and colours come from a slot model in the bench, indexed by the entry index XOR the byte-order bit. This lets every neighbour-preservation case and every swap case be checked against arithmetic rather than against the design.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;

  // Which 16-bit half of a packed word an entry occupies.
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  // Byte-order control flips the index LSB before the half is chosen.
  function automatic half_e pick_half(input logic idx_lsb, input logic swap);
    return half_e'(idx_lsb ^ swap);
  endfunction

endpackage

// File: rtl/pal_pack.sv
`timescale 1ns/1ps
module pal_pack
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int IN_W   = 16,
  parameter int COMP_W = 5
) (
  input  logic                  wr_en,
  input  logic                  bpp8_en,
  input  logic                  swap_halves,
  input  logic [IDX_W-1:0]      wr_index,
  input  logic [IN_W-1:0]       wr_red,
  input  logic [IN_W-1:0]       wr_green,
  input  logic [IN_W-1:0]       wr_blue,
  output logic                  wr_act,
  output logic [IDX_W-2:0]      wr_word,
  output half_e                 wr_half,
  output logic [3*COMP_W-1:0]   wr_entry
);

  localparam int DROP_W = IN_W - COMP_W;

  logic unused_low_bits;

  always_comb begin
    wr_act   = wr_en & bpp8_en;
    wr_word  = wr_index[IDX_W-1:1];
    wr_half  = pick_half(wr_index[0], swap_halves);
    wr_entry = {wr_blue[IN_W-1 -: COMP_W],
                wr_green[IN_W-1 -: COMP_W],
                wr_red[IN_W-1 -: COMP_W]};
  end

  assign unused_low_bits = ^{wr_red[DROP_W-1:0], wr_green[DROP_W-1:0], wr_blue[DROP_W-1:0]};

endmodule

// File: rtl/pal_store.sv
`timescale 1ns/1ps
module pal_store
  import pal_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int ENTRY_W = 15
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_act,
  input  logic [IDX_W-2:0]            wr_word,
  input  half_e                       wr_half,
  input  logic [ENTRY_W-1:0]          wr_entry,
  input  logic [IDX_W-2:0]            rd_sel,
  output logic [2*(ENTRY_W+1)-1:0]    rd_word,
  input  logic [IDX_W-2:0]            lk_word,
  input  half_e                       lk_half,
  output logic [ENTRY_W-1:0]          lk_entry
);

  localparam int WSEL_W = IDX_W - 1;
  localparam int WORDS  = 1 << WSEL_W;
  localparam int RD_W   = 2 * (ENTRY_W + 1);

  logic [ENTRY_W-1:0] lo_arr [WORDS];
  logic [ENTRY_W-1:0] hi_arr [WORDS];

  // One pair of half registers per word with its own write enable.
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic               hit;
    logic [ENTRY_W-1:0] lo_d, hi_d, lo_q, hi_q;

    always_comb begin
      hit  = wr_act && (wr_word == WSEL_W'(w));
      lo_d = lo_q;
      hi_d = hi_q;
      if (wr_half == HALF_HI) hi_d = wr_entry;
      else                    lo_d = wr_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (hit) begin
        lo_q <= lo_d;
        hi_q <= hi_d;
      end
    end

    assign lo_arr[w] = lo_q;
    assign hi_arr[w] = hi_q;
  end

  logic [RD_W-1:0]    rd_word_d;
  logic [ENTRY_W-1:0] lk_entry_d;

  always_comb begin
    rd_word_d  = {1'b0, hi_arr[rd_sel], 1'b0, lo_arr[rd_sel]};
    lk_entry_d = (lk_half == HALF_HI) ? hi_arr[lk_word] : lo_arr[lk_word];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word  <= '0;
      lk_entry <= '0;
    end else begin
      rd_word  <= rd_word_d;
      lk_entry <= lk_entry_d;
    end
  end

endmodule

// File: rtl/pal_expand.sv
`timescale 1ns/1ps
module pal_expand #(
  parameter int COMP_W = 5,
  parameter int OUT_W  = 8
) (
  input  logic [COMP_W-1:0] comp,
  output logic [OUT_W-1:0]  wide
);

  // Bit replication: output bits walk down the component, wrapping at its LSB.
  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    assign wide[OUT_W-1-i] = comp[COMP_W-1-(i % COMP_W)];
  end

endmodule

// File: rtl/pal_lut.sv
`timescale 1ns/1ps
module pal_lut
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int IN_W   = 16,
  parameter int COMP_W = 5,
  parameter int OUT_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bpp8_en,
  input  logic                          swap_halves,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_index,
  input  logic [IN_W-1:0]               wr_red,
  input  logic [IN_W-1:0]               wr_green,
  input  logic [IN_W-1:0]               wr_blue,
  input  logic [IDX_W-2:0]              rd_word_sel,
  output logic [2*(3*COMP_W+1)-1:0]     rd_word_data,
  input  logic [IDX_W-1:0]              pix_index,
  output logic [OUT_W-1:0]              pix_red,
  output logic [OUT_W-1:0]              pix_green,
  output logic [OUT_W-1:0]              pix_blue
);

  localparam int ENTRY_W = 3 * COMP_W;
  localparam int NCOMP   = 3;

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic               wr_act;
  logic [IDX_W-2:0]   wr_word;
  half_e              wr_half;
  logic [ENTRY_W-1:0] wr_entry;

  pal_pack #(.IDX_W(IDX_W), .IN_W(IN_W), .COMP_W(COMP_W)) u_pack (
    .wr_en       (wr_en),
    .bpp8_en     (bpp8_en),
    .swap_halves (swap_halves),
    .wr_index    (wr_index),
    .wr_red      (wr_red),
    .wr_green    (wr_green),
    .wr_blue     (wr_blue),
    .wr_act      (wr_act),
    .wr_word     (wr_word),
    .wr_half     (wr_half),
    .wr_entry    (wr_entry)
  );

  logic [IDX_W-2:0]   lk_word;
  half_e              lk_half;
  logic [ENTRY_W-1:0] lk_entry;

  always_comb begin
    lk_word = pix_index[IDX_W-1:1];
    lk_half = pick_half(pix_index[0], swap_halves);
  end

  pal_store #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr_act   (wr_act),
    .wr_word  (wr_word),
    .wr_half  (wr_half),
    .wr_entry (wr_entry),
    .rd_sel   (rd_word_sel),
    .rd_word  (rd_word_data),
    .lk_word  (lk_word),
    .lk_half  (lk_half),
    .lk_entry (lk_entry)
  );

  logic [OUT_W-1:0] comp_wide [NCOMP];

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    pal_expand #(.COMP_W(COMP_W), .OUT_W(OUT_W)) u_expand (
      .comp (lk_entry[c*COMP_W +: COMP_W]),
      .wide (comp_wide[c])
    );
  end

  assign pix_red   = comp_wide[0];
  assign pix_green = comp_wide[1];
  assign pix_blue  = comp_wide[2];

endmodule

// File: rtl/pal_lut_chk.sv
`timescale 1ns/1ps
module pal_lut_chk #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 5,
  parameter int OUT_W  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bpp8_en,
  input logic                      swap_halves,
  input logic                      wr_en,
  input logic [IDX_W-2:0]          rd_word_sel,
  input logic [2*(3*COMP_W+1)-1:0] rd_word_data,
  input logic [IDX_W-1:0]          pix_index,
  input logic [OUT_W-1:0]          pix_red,
  input logic [OUT_W-1:0]          pix_green,
  input logic [OUT_W-1:0]          pix_blue
);

  logic wr_live;
  assign wr_live = wr_en & bpp8_en;

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_live) && $stable(rd_word_sel)) |=> $stable(rd_word_data)); // R4

  AST_MODE_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!bpp8_en) && $stable(rd_word_sel)) |=> $stable(rd_word_data)); // R6

  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_live) && $stable(pix_index) && $stable(swap_halves))
      |=> ($stable(pix_red) && $stable(pix_green) && $stable(pix_blue))); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (rd_word_data == '0 && pix_red == '0 && pix_green == '0 && pix_blue == '0)); // R9

endmodule

bind pal_lut pal_lut_chk #(.IDX_W(IDX_W), .COMP_W(COMP_W), .OUT_W(OUT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bpp8_en      (bpp8_en),
  .swap_halves  (swap_halves),
  .wr_en        (wr_en),
  .rd_word_sel  (rd_word_sel),
  .rd_word_data (rd_word_data),
  .pix_index    (pix_index),
  .pix_red      (pix_red),
  .pix_green    (pix_green),
  .pix_blue     (pix_blue)
);

// File: tb/pal_lut_tb.sv
`timescale 1ns/1ps
module pal_lut_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bpp8_en, swap_halves, wr_en;
  logic [7:0]  wr_index, pix_index;
  logic [15:0] wr_red, wr_green, wr_blue;
  logic [6:0]  rd_word_sel;
  logic [31:0] rd_word_data;
  logic [7:0]  pix_red, pix_green, pix_blue;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [14:0] slot [256];

  always #5 clk = ~clk;

  pal_lut u_dut (
    .clk(clk), .rst_n(rst_n), .bpp8_en(bpp8_en), .swap_halves(swap_halves),
    .wr_en(wr_en), .wr_index(wr_index), .wr_red(wr_red), .wr_green(wr_green),
    .wr_blue(wr_blue), .rd_word_sel(rd_word_sel), .rd_word_data(rd_word_data),
    .pix_index(pix_index), .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue)
  );

  function automatic logic [14:0] pack(input logic [15:0] r, g, b);
    return {b[15:11], g[15:11], r[15:11]};
  endfunction

  function automatic logic [7:0] widen(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [31:0] word_exp(input int w);
    return {1'b0, slot[2*w+1], 1'b0, slot[2*w]};
  endfunction

  function automatic logic [23:0] pix_exp(input logic [7:0] n, input logic sw);
    logic [14:0] e;
    e = slot[n ^ {7'd0, sw}];
    return {widen(e[4:0]), widen(e[9:5]), widen(e[14:10])};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_entry(input logic [7:0] n, input logic [15:0] r, g, b);
    wr_index = n; wr_red = r; wr_green = g; wr_blue = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (bpp8_en) slot[n ^ {7'd0, swap_halves}] = pack(r, g, b);
  endtask

  task automatic read_word(input int w, input string req);
    rd_word_sel = 7'(w);
    @(negedge clk);
    check(req, rd_word_data, word_exp(w));
  endtask

  task automatic lookup(input int n, input string req);
    pix_index = 8'(n);
    @(negedge clk);
    check(req, {8'd0, pix_red, pix_green, pix_blue}, {8'd0, pix_exp(8'(n), swap_halves)});
  endtask

  task automatic fill(input logic [15:0] salt, input int step);
    for (int n = 0; n < 256; n += step)
      write_entry(8'(n), 16'(n * 977) + salt, 16'(n * 2503) ^ salt, ~16'(n * 331) + salt);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b1; bpp8_en = 1'b1; swap_halves = 1'b0; wr_en = 1'b0;
    wr_index = '0; wr_red = '0; wr_green = '0; wr_blue = '0;
    rd_word_sel = '0; pix_index = '0;
    for (int i = 0; i < 256; i++) slot[i] = '0;
    #1 rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    // R9: outputs cleared while in reset
    check("R9 reset word", rd_word_data, 32'd0);
    check("R9 reset pix", {8'd0, pix_red, pix_green, pix_blue}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: table empty after reset
    for (int w = 0; w < 128; w++) read_word(w, "R9 cleared table");

    // R1 R3 R5: fill in normal order, read back every word
    fill(16'h1234, 1);
    for (int w = 0; w < 128; w++) read_word(w, "R1 R3 R5 packed word");
    // R7: every lookup in normal order
    for (int n = 0; n < 256; n++) lookup(n, "R7 lookup");

    // R4: rewrite only even entries, odd halves must survive
    fill(16'hA5C3, 2);
    for (int w = 0; w < 128; w++) read_word(w, "R4 neighbour kept");

    // R3: truncation of low bits, explicit value 0x43E0 in low half
    write_entry(8'd20, 16'h07FF, 16'hF800, 16'h8400);
    read_word(10, "R3 truncation");
    check("R3 field layout", {16'd0, rd_word_data[15:0]}, 32'h0000_43E0);

    // R8: read latency exactly one clock
    rd_word_sel = 7'd3;
    @(negedge clk);
    rd_word_sel = 7'd10;
    #2 check("R8 before edge", rd_word_data, word_exp(3));
    @(negedge clk);
    check("R8 after edge", rd_word_data, word_exp(10));

    // R7: lookup latency exactly one clock
    pix_index = 8'd7;
    @(negedge clk);
    pix_index = 8'd200;
    #2 check("R7 before edge", {8'd0, pix_red, pix_green, pix_blue}, {8'd0, pix_exp(8'd7, 1'b0)});
    @(negedge clk);
    check("R7 after edge", {8'd0, pix_red, pix_green, pix_blue}, {8'd0, pix_exp(8'd200, 1'b0)});

    // R2: swapped byte order for lookups
    swap_halves = 1'b1;
    for (int n = 0; n < 256; n++) lookup(n, "R2 swapped lookup");
    // R2: swapped write of index 5 lands in the low half of word 2
    write_entry(8'd5, 16'hFFFF, 16'h0000, 16'h8000);
    read_word(2, "R2 swapped write");
    check("R2 low half", {17'd0, rd_word_data[14:0]}, {17'd0, 15'h4000 | 15'h001F});
    read_word(3, "R4 other word untouched");

    // R6: mode off, writes ignored
    bpp8_en = 1'b0;
    swap_halves = 1'b0;
    write_entry(8'd10, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    write_entry(8'd11, 16'h0000, 16'h0000, 16'h0000);
    read_word(5, "R6 ignored write");
    lookup(10, "R6 ignored lookup");
    bpp8_en = 1'b1;

    // R1 R5: full sweep once more after mixed activity
    for (int w = 0; w < 128; w++) read_word(w, "R1 R5 final sweep");

    done = 1'b1;
    finish_run();
  end

endmodule